// File: doc/BRIEF.md
# Tick Compare Timer with Disable

This block keeps a free-running tick count and watches it with two comparators, one for the supervisor level and one for the hypervisor level. Each comparator owns a compare register whose top bit turns its interrupt off and whose lower bits hold the count value to match. Writing a compare register arms its comparator, but only if the disable bit is clear and the value lies ahead of the count. When an armed comparator sees the count equal to its value, it fires once and disarms itself.

A supervisor match raises bit 16 of a soft interrupt register. Software can overwrite that register or set and clear its bits. A hypervisor match writes 1 into a one-bit pending flag, and that flag drives the hypervisor interrupt line. While the thread is halted, a hypervisor match is dropped. All register writes go through one port made of a write enable, an address and a data word.

Top module: `tct_timer`

## Requirements
- R1: `tickCount` is 0 out of reset and grows by one on every clock edge. It wraps to 0 after 2^CW-1.
- R2: A write to a compare register arms its comparator only when data bit CW is 0 and data bits CW-1:0 are strictly greater than `tickCount` in the write cycle. A value that equals or lies behind the count never fires, even after the count wraps.
- R3: An armed comparator fires in the cycle its match value equals `tickCount`. On the next edge the matching pulse output (`supMatch` or `hypMatch`) goes high for exactly one cycle. The comparator then stays quiet until its compare register is written again.
- R4: A compare write with data bit CW set cancels any match that is already armed for that comparator.
- R5: A supervisor pulse is accompanied by bit 16 of `softIntReg` being 1.
- R6: A hypervisor pulse writes 1 into `hypPending`.
- R7: When `haltIn` is high in the cycle a hypervisor match would fire, no pulse is produced and `hypPending` is unchanged. That arming is still used up.
- R8: `hypIrq` is high exactly when `hypPending` is 1. Address 5 loads `hypPending` from data bit 0.
- R9: The soft interrupt register is written as follows, with write data zero-extended to SOFT_W bits. Address 2 overwrites it. Address 3 ORs the data in. Address 4 clears the bits where the data is 1. A supervisor match in the same cycle still leaves bit 16 set.
- R10: Address 0 selects the supervisor compare register and address 1 the hypervisor one. If a compare register is written in the very cycle its comparator would fire, the write wins: no pulse, and arming follows R2 for the new value. Addresses 6 and 7 have no effect.
- R11: Out of reset, all outputs are 0 and neither comparator is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select (0 sup compare, 1 hyp compare, 2 soft write, 3 soft set, 4 soft clear, 5 pending) |
| wrData | input | CW+1 | Write data; bit CW is the compare disable flag |
| haltIn | input | 1 | Thread halted; drops hypervisor matches |
| tickCount | output | CW | Current tick count |
| softIntReg | output | SOFT_W | Soft interrupt register |
| hypPending | output | 1 | Hypervisor interrupt-pending flag |
| hypIrq | output | 1 | Hypervisor interrupt line |
| supMatch | output | 1 | One-cycle supervisor match pulse |
| hypMatch | output | 1 | One-cycle hypervisor match pulse |

## Verification
The assertions check these rules on every cycle:
- the count steps by exactly one;
- a pulse never lasts two cycles;
- a supervisor pulse always comes with bit 16 set, and a hypervisor pulse with the pending flag set;
- a disabling write always leaves the comparator unarmed;
- no hypervisor pulse follows a halted cycle.

Other behaviour depends on values written many cycles earlier, so only the bench scenarios can show it. This covers refusing a value at or behind the count, a disable landing between arming and match, a rewrite landing on the match cycle, and the count wrapping past an unarmed value.

// File: rtl/tct_pkg.sv
package tct_pkg;

  typedef enum logic [2:0] {
    A_SUP_CMP  = 3'd0,
    A_HYP_CMP  = 3'd1,
    A_SOFT_WR  = 3'd2,
    A_SOFT_SET = 3'd3,
    A_SOFT_CLR = 3'd4,
    A_PEND     = 3'd5
  } tct_addr_e;

  typedef struct packed {
    logic supCmpWe;
    logic hypCmpWe;
    logic softWe;
    logic softSet;
    logic softClr;
    logic pendWe;
    logic supFire;
    logic hypFire;
  } tct_strobe_t;

endpackage

// File: rtl/tct_ctrl.sv
module tct_ctrl
  import tct_pkg::*;
#(
  parameter int CW = 63
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [CW:0]         wrData,
  input  logic                haltIn,
  input  logic [CW-1:0]       cnt,
  input  logic [1:0][CW-1:0]  matchVal,
  output tct_strobe_t         strb
);

  localparam int NCMP = 2;

  logic [NCMP-1:0] armed;
  logic [NCMP-1:0] cmpWr;
  logic [NCMP-1:0] hit;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    localparam tct_addr_e MYADDR = (i == 0) ? A_SUP_CMP : A_HYP_CMP;

    assign cmpWr[i] = wrEn && (wrAddr == MYADDR);
    assign hit[i]   = armed[i] && (matchVal[i] == cnt) && !cmpWr[i];

    always_ff @(posedge clk) begin
      if (!rstN)
        armed[i] <= 1'b0;
      else if (cmpWr[i])
        armed[i] <= !wrData[CW] && (wrData[CW-1:0] > cnt);
      else if (hit[i])
        armed[i] <= 1'b0;
    end

    // R4: a write carrying the disable flag leaves nothing armed
    a_r4_disable_cancels : assert property (@(posedge clk) disable iff (!rstN)
      (cmpWr[i] && wrData[CW]) |=> !armed[i]);

    // R2: a value not ahead of the count never arms
    a_r2_behind_no_arm : assert property (@(posedge clk) disable iff (!rstN)
      (cmpWr[i] && (wrData[CW-1:0] <= cnt)) |=> !armed[i]);

    // R3: a firing comparator disarms itself
    a_r3_fire_once : assert property (@(posedge clk) disable iff (!rstN)
      hit[i] |=> !armed[i]);
  end

  always_comb begin
    strb          = '0;
    strb.supCmpWe = cmpWr[0];
    strb.hypCmpWe = cmpWr[1];
    strb.softWe   = wrEn && (wrAddr == A_SOFT_WR);
    strb.softSet  = wrEn && (wrAddr == A_SOFT_SET);
    strb.softClr  = wrEn && (wrAddr == A_SOFT_CLR);
    strb.pendWe   = wrEn && (wrAddr == A_PEND);
    strb.supFire  = hit[0];
    strb.hypFire  = hit[1] && !haltIn;
  end

endmodule

// File: rtl/tct_datapath.sv
module tct_datapath
  import tct_pkg::*;
#(
  parameter int CW      = 63,
  parameter int SOFT_W  = 17,
  parameter int SUP_BIT = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CW:0]         wrData,
  input  tct_strobe_t         strb,
  output logic [CW-1:0]       cnt,
  output logic [1:0][CW-1:0]  matchVal,
  output logic [SOFT_W-1:0]   softInt,
  output logic                pend,
  output logic                supPulse,
  output logic                hypPulse
);

  localparam int DW = CW + 1;
  localparam int XW = (DW > SOFT_W) ? DW : SOFT_W;

  logic [1:0][DW-1:0] cmpReg;
  logic [XW-1:0]      wrExt;
  logic [SOFT_W-1:0]  wrSoft;
  logic [SOFT_W-1:0]  softNext;
  logic               pendNext;

  assign wrExt  = XW'(wrData);
  assign wrSoft = wrExt[SOFT_W-1:0];

  for (genvar i = 0; i < 2; i++) begin : g_match
    assign matchVal[i] = cmpReg[i][CW-1:0];
  end

  always_comb begin
    softNext = softInt;
    if (strb.softWe)
      softNext = wrSoft;
    else if (strb.softSet)
      softNext = softInt | wrSoft;
    else if (strb.softClr)
      softNext = softInt & ~wrSoft;
    if (strb.supFire)
      softNext[SUP_BIT] = 1'b1;
  end

  always_comb begin
    pendNext = pend;
    if (strb.pendWe)
      pendNext = wrData[0];
    if (strb.hypFire)
      pendNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      cmpReg   <= '0;
      softInt  <= '0;
      pend     <= 1'b0;
      supPulse <= 1'b0;
      hypPulse <= 1'b0;
    end else begin
      cnt      <= cnt + 1'b1;
      if (strb.supCmpWe) cmpReg[0] <= wrData;
      if (strb.hypCmpWe) cmpReg[1] <= wrData;
      softInt  <= softNext;
      pend     <= pendNext;
      supPulse <= strb.supFire;
      hypPulse <= strb.hypFire;
    end
  end

  a_r1_count_step : assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (cnt == CW'($past(cnt) + 1'b1)));

  a_r3_sup_one_cycle : assert property (@(posedge clk) disable iff (!rstN)
    supPulse |=> !supPulse);

  a_r3_hyp_one_cycle : assert property (@(posedge clk) disable iff (!rstN)
    hypPulse |=> !hypPulse);

  a_r5_sup_sets_bit : assert property (@(posedge clk) disable iff (!rstN)
    supPulse |-> softInt[SUP_BIT]);

  a_r6_hyp_sets_pend : assert property (@(posedge clk) disable iff (!rstN)
    hypPulse |-> pend);

endmodule

// File: rtl/tct_timer.sv
module tct_timer
  import tct_pkg::*;
#(
  parameter int CW      = 63,
  parameter int SOFT_W  = 17,
  parameter int SUP_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CW:0]       wrData,
  input  logic              haltIn,
  output logic [CW-1:0]     tickCount,
  output logic [SOFT_W-1:0] softIntReg,
  output logic              hypPending,
  output logic              hypIrq,
  output logic              supMatch,
  output logic              hypMatch
);

  tct_strobe_t        strb;
  logic [1:0][CW-1:0] matchVal;
  logic               pend;

  tct_ctrl #(.CW(CW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .haltIn   (haltIn),
    .cnt      (tickCount),
    .matchVal (matchVal),
    .strb     (strb)
  );

  tct_datapath #(.CW(CW), .SOFT_W(SOFT_W), .SUP_BIT(SUP_BIT)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrData   (wrData),
    .strb     (strb),
    .cnt      (tickCount),
    .matchVal (matchVal),
    .softInt  (softIntReg),
    .pend     (pend),
    .supPulse (supMatch),
    .hypPulse (hypMatch)
  );

  assign hypPending = pend;
  assign hypIrq     = pend;

  // R7: a halted cycle never yields a hypervisor pulse
  a_r7_halt_blocks : assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(haltIn)) |-> !hypMatch);

endmodule

// File: tb/tct_timer_tb.sv
`timescale 1ns/1ps
module tct_timer_tb_top;

  localparam int CW = 12;
  localparam int SW = 17;
  localparam int SB = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [CW:0]   wrData = '0;
  logic          haltIn = 1'b0;
  logic [CW-1:0] tickCount;
  logic [SW-1:0] softIntReg;
  logic          hypPending, hypIrq, supMatch, hypMatch;

  always #2.5 clk = ~clk;

  tct_timer #(.CW(CW), .SOFT_W(SW), .SUP_BIT(SB)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .haltIn(haltIn), .tickCount(tickCount), .softIntReg(softIntReg),
    .hypPending(hypPending), .hypIrq(hypIrq), .supMatch(supMatch),
    .hypMatch(hypMatch)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  logic [CW-1:0] mCnt;
  logic [CW:0]   mCmp [2];
  logic          mArm [2];
  logic [SW-1:0] mSoft;
  logic          mPend, mSupP, mHypP;
  int            supSeen, hypSeen, wraps;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [SW-1:0] ext(input logic [CW:0] d);
    logic [SW-1:0] r = '0;
    for (int b = 0; b <= CW && b < SW; b++) r[b] = d[b];
    return r;
  endfunction

  task automatic model_reset();
    mCnt = '0; mCmp[0] = '0; mCmp[1] = '0; mArm[0] = 0; mArm[1] = 0;
    mSoft = '0; mPend = 0; mSupP = 0; mHypP = 0;
  endtask

  task automatic model_edge(input logic we, input logic [2:0] a, input logic [CW:0] d, input logic h);
    logic [CW-1:0] pc = mCnt;
    logic wr [2];
    logic hit [2];
    logic sf, hf;
    for (int i = 0; i < 2; i++) begin
      wr[i]  = we && (a == 3'(i));
      hit[i] = mArm[i] && (mCmp[i][CW-1:0] == pc) && !wr[i];
    end
    sf = hit[0];
    hf = hit[1] && !h;
    for (int i = 0; i < 2; i++) begin
      if (wr[i]) begin
        mCmp[i] = d;
        mArm[i] = !d[CW] && (d[CW-1:0] > pc);
      end else if (hit[i]) mArm[i] = 0;
    end
    if (we && a == 3'd2) mSoft = ext(d);
    else if (we && a == 3'd3) mSoft = mSoft | ext(d);
    else if (we && a == 3'd4) mSoft = mSoft & ~ext(d);
    if (sf) mSoft[SB] = 1'b1;
    if (we && a == 3'd5) mPend = d[0];
    if (hf) mPend = 1'b1;
    mSupP = sf; mHypP = hf;
    mCnt = pc + 1'b1;
  endtask

  task automatic compare_all();
    chk("R1 tickCount", 32'(tickCount), 32'(mCnt));
    chk("R3 supMatch", 32'(supMatch), 32'(mSupP));
    chk("R7 hypMatch", 32'(hypMatch), 32'(mHypP));
    chk("R9 softIntReg", 32'(softIntReg), 32'(mSoft));
    chk("R6 hypPending", 32'(hypPending), 32'(mPend));
    chk("R8 hypIrq", 32'(hypIrq), 32'(mPend));
    if (supMatch) supSeen++;
    if (hypMatch) hypSeen++;
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [CW:0] d, input logic h);
    wrEn = we; wrAddr = a; wrData = d; haltIn = h;
    @(posedge clk);
    model_edge(we, a, d, h);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n, input logic h);
    for (int k = 0; k < n; k++) step(1'b0, 3'd0, '0, h);
  endtask

  function automatic logic [CW:0] cmpv(input logic dis, input logic [CW-1:0] v);
    return {dis, v};
  endfunction

  initial begin
    int s0;
    s0 = $urandom(32'h5eed_1234);
    model_reset();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 tickCount", 32'(tickCount), 0);
    chk("R11 softIntReg", 32'(softIntReg), 0);
    chk("R11 hypIrq", 32'(hypIrq), 0);
    chk("R11 matches", 32'({supMatch, hypMatch}), 0);
    rstN = 1'b1;
    idle(3, 0);

    // R3: armed supervisor match fires once; R5: bit 16 set
    supSeen = 0;
    step(1, 3'd0, cmpv(0, mCnt + 12'd3), 0);
    idle(8, 0);
    chk("R3 single sup pulse", 32'(supSeen), 1);
    chk("R5 soft bit 16", 32'(softIntReg[SB]), 1);

    // R9: clearing via write address 2 and set/clear ops
    step(1, 3'd2, 13'h0a5, 0);
    step(1, 3'd3, 13'h100, 0);
    step(1, 3'd4, 13'h005, 0);
    chk("R9 soft ops", 32'(softIntReg), 32'h1a0);

    // R2: value equal to count and behind count never arm
    supSeen = 0;
    step(1, 3'd0, cmpv(0, mCnt), 0);
    idle(6, 0);
    step(1, 3'd0, cmpv(0, mCnt - 12'd2), 0);
    idle(6, 0);
    chk("R2 no arm when not ahead", 32'(supSeen), 0);

    // R4: disable flag cancels armed match
    supSeen = 0;
    step(1, 3'd0, cmpv(0, mCnt + 12'd10), 0);
    idle(2, 0);
    step(1, 3'd0, cmpv(1, mCnt + 12'd6), 0);
    idle(14, 0);
    chk("R4 disabled no pulse", 32'(supSeen), 0);

    // R6/R8: hypervisor match sets pending, irq follows
    step(1, 3'd5, 13'h0, 0);
    hypSeen = 0;
    step(1, 3'd1, cmpv(0, mCnt + 12'd4), 0);
    idle(6, 0);
    chk("R6 hyp pulse once", 32'(hypSeen), 1);
    chk("R8 irq follows pending", 32'(hypIrq), 1);
    step(1, 3'd5, 13'h0, 0);
    chk("R8 pending cleared", 32'(hypIrq), 0);

    // R7: halt drops hypervisor match
    hypSeen = 0;
    step(1, 3'd1, cmpv(0, mCnt + 12'd4), 0);
    idle(6, 1);
    idle(2, 0);
    chk("R7 halted no pulse", 32'(hypSeen), 0);
    chk("R7 pending unchanged", 32'(hypPending), 0);

    // R10: rewrite on match cycle wins; unused addresses ignored
    supSeen = 0;
    step(1, 3'd0, cmpv(0, mCnt + 12'd2), 0);
    idle(1, 0);
    step(1, 3'd0, cmpv(0, mCnt + 12'd5), 0);
    chk("R10 no pulse on rewrite", 32'(supSeen), 0);
    idle(7, 0);
    chk("R10 later pulse", 32'(supSeen), 1);
    step(1, 3'd6, 13'h1fff, 0);
    step(1, 3'd7, 13'h1fff, 0);

    // random mix; covers R1 wrap several times
    wraps = 0;
    for (int n = 0; n < 12000; n++) begin
      logic we, h, dis;
      logic [2:0] a;
      logic [CW:0] d;
      we  = ($urandom % 8) == 0;
      a   = 3'($urandom % 8);
      h   = ($urandom % 5) == 0;
      dis = ($urandom % 4) == 0;
      if (a <= 3'd1) d = cmpv(dis, mCnt + 12'($urandom % 40) - 12'd5);
      else d = 13'($urandom);
      step(we, a, d, h);
      if (mCnt == '0) wraps++;
    end
    chk("R1 wrapped", 32'(wraps >= 2), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule